// File: doc/BRIEF.md
# Memory-Based Programmable Delay Line

The block delays a stream of data words by a number of samples chosen at run time, from 1 up to a parameter `N`. The words are held in an inferred synchronous dual-port array, not in a flip-flop chain. One port only writes and the other only reads, and both run on the one clock. A write pointer walks the array modulo its depth. The read address trails that pointer by the programmed delay, so the registered read returns the sample that entered `delay_sel` enabled cycles earlier.

A parameter picks how the array behaves when a read and a write hit the same address on the same edge. In write-first mode the new word is passed straight into the read register. In read-first mode the array returns the old word, and a one-bit forwarding flag with a bypass register supplies the new one. Both modes give the same timing at the ports, including a delay of one. The array has no reset. A fill counter and a valid flag mark the output as trustworthy only once enough fresh samples have gone in. A delay outside 1..N is clamped into range and raises a sticky error flag.

Top module: `mem_delay_line`

## Requirements
- R1: Following a synchronous active-high reset, `out_valid` and `cfg_err` are 0.
- R2: With the effective delay D held constant, each rising edge with `in_en` high makes `out_data` equal to the sample accepted D enabled edges earlier. The sample accepted on that same edge counts as 1. The new value is visible after that edge.
- R3: On an edge with `in_en` low and no change of effective delay, `out_data` and `out_valid` keep their values. Delay is counted in enabled samples, not in clock cycles.
- R4: A delay of 1 returns each sample on the edge that accepts it, in both read-during-write modes.
- R5: A delay equal to `N` returns the oldest word the array holds.
- R6: `out_valid` goes to 1 on the enabled edge that accepts the D-th sample after reset or after a delay change. That first valid output is the first sample accepted since then.
- R7: When the effective delay changes, the fill count restarts from zero and `out_valid` drops. If `in_en` is high on that edge, its sample counts as the first of the new fill.
- R8: A `delay_sel` of 0 behaves as a delay of 1 and sets `cfg_err` on the next edge.
- R9: A `delay_sel` greater than `N` behaves as a delay of `N` and sets `cfg_err`. `cfg_err` stays 1 until reset.
- R10: The read-during-write parameter does not change port behaviour. Both settings produce identical outputs for identical stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the whole block |
| rst | input | 1 | Synchronous active-high reset (does not clear the array) |
| in_en | input | 1 | Accept `in_data` and advance the line on this edge |
| in_data | input | W | Sample to delay |
| delay_sel | input | DW | Requested delay in samples, legal range 1..N |
| out_data | output | W | Delayed sample |
| out_valid | output | 1 | `out_data` holds a sample written since reset or the last delay change |
| cfg_err | output | 1 | Sticky flag: an out-of-range delay was requested |

## Verification
The bench builds two copies that receive identical stimulus. One is write-first with `N`=16, a power-of-two depth where the address arithmetic wraps on its own. The other is read-first with `N`=12, which exercises the explicit wrap of the read address and the forwarding path. Both copies use a 5-bit `delay_sel`. This lets one requested value of 16 be legal for the first copy while the second clamps it. It also lets a value of 20 push both copies past their maximum.

// File: rtl/mem_delay_line.sv
module mem_delay_line #(
  parameter int W           = 16,
  parameter int N           = 256,
  parameter int DW          = $clog2(N + 1),
  parameter bit WRITE_FIRST = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_en,
  input  logic [W-1:0]  in_data,
  input  logic [DW-1:0] delay_sel,
  output logic [W-1:0]  out_data,
  output logic          out_valid,
  output logic          cfg_err
);
  localparam int AW = $clog2(N);

  logic [W-1:0]  mem [N];
  logic [W-1:0]  rd_q;
  logic [AW-1:0] wptr, raddr, back;
  logic [DW-1:0] d_eff, d_q, fill, base;
  logic [DW:0]   fill_inc;
  logic          bad, chg;

  assign bad      = (delay_sel == '0) || (delay_sel > DW'(N));
  assign d_eff    = (delay_sel == '0) ? DW'(1) : (delay_sel > DW'(N) ? DW'(N) : delay_sel);
  assign chg      = d_eff != d_q;
  assign base     = chg ? '0 : fill;
  assign fill_inc = {1'b0, base} + (DW+1)'(1);
  assign back     = AW'(d_eff - DW'(1));
  assign raddr    = (wptr >= back) ? wptr - back : wptr - back + AW'(N);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      fill      <= '0;
      d_q       <= DW'(1);
      out_valid <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      cfg_err <= cfg_err | bad;
      d_q     <= d_eff;
      if (in_en) begin
        wptr      <= (wptr == AW'(N - 1)) ? '0 : wptr + AW'(1);
        fill      <= (fill_inc > (DW+1)'(N)) ? DW'(N) : fill_inc[DW-1:0];
        out_valid <= fill_inc >= {1'b0, d_eff};
      end else if (chg) begin
        fill      <= '0;
        out_valid <= 1'b0;
      end
    end
  end

  generate
    if (WRITE_FIRST) begin : g_wf
      always_ff @(posedge clk) begin
        if (in_en) begin
          mem[wptr] <= in_data;
          rd_q      <= (raddr == wptr) ? in_data : mem[raddr];
        end
      end
      assign out_data = rd_q;
    end else begin : g_rf
      logic [W-1:0] byp_q;
      logic         fwd_q;
      always_ff @(posedge clk) begin
        if (in_en) begin
          mem[wptr] <= in_data;
          rd_q      <= mem[raddr];
          byp_q     <= in_data;
          fwd_q     <= raddr == wptr;
        end
      end
      assign out_data = fwd_q ? byp_q : rd_q;
    end
  endgenerate

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!in_en && !chg) |=> ($stable(out_data) && $stable(out_valid)));
  p_valid_needs_sample_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_en));
  p_fill_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (fill <= DW'(N)) && (wptr <= AW'(N - 1)));
  p_change_drops_valid_r7: assert property (@(posedge clk) disable iff (rst)
    (chg && d_eff != DW'(1)) |=> !out_valid);
  p_err_set_r8: assert property (@(posedge clk) disable iff (rst)
    bad |=> cfg_err);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);
endmodule

// File: tb/sim_mem_delay_line.sv
module sim_mem_delay_line;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_en = 1'b0;
  logic [15:0] in_data = '0;
  logic [4:0]  delay_sel = 5'd4;
  logic [15:0] od [2];
  logic        ov [2];
  logic        oe [2];

  always #4 clk = ~clk;

  mem_delay_line #(.W(16), .N(16), .DW(5), .WRITE_FIRST(1'b1)) u0 (
    .clk(clk), .rst(rst), .in_en(in_en), .in_data(in_data), .delay_sel(delay_sel),
    .out_data(od[0]), .out_valid(ov[0]), .cfg_err(oe[0]));
  mem_delay_line #(.W(16), .N(12), .DW(5), .WRITE_FIRST(1'b0)) u1 (
    .clk(clk), .rst(rst), .in_en(in_en), .in_data(in_data), .delay_sel(delay_sel),
    .out_data(od[1]), .out_valid(ov[1]), .cfg_err(oe[1]));

  int checks = 0, fails = 0;
  int depth [2] = '{16, 12};
  logic [15:0] hist [$];
  int  eff [2], cnt [2];
  bit  chg [2], errp [2];
  bit  exp_v [2], exp_e [2];
  logic [15:0] exp_d [2];

  function automatic int clampd(int d, int n);
    return d == 0 ? 1 : (d > n ? n : d);
  endfunction

  task automatic cmp(string req, int i, logic [15:0] act, logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s inst%0d t=%0t actual=%0h expected=%0h", req, i, $time, act, expv);
    end
  endtask

  task automatic step(bit en, logic [15:0] d, int dly);
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin chg[i] = 0; errp[i] = 0; end
    in_en = en; in_data = d; delay_sel = 5'(dly);
    for (int i = 0; i < 2; i++) begin
      int ne = clampd(dly, depth[i]);
      if (dly == 0 || dly > depth[i]) errp[i] = 1;
      if (ne != eff[i]) begin eff[i] = ne; cnt[i] = 0; chg[i] = 1; end
      if (en) cnt[i]++;
    end
    if (en) hist.push_back(d);
  endtask

  task automatic do_reset(int dly);
    @(negedge clk);
    rst = 1; in_en = 0; delay_sel = 5'(dly);
    for (int i = 0; i < 2; i++) begin
      eff[i] = clampd(dly, depth[i]); cnt[i] = 0; chg[i] = 0; errp[i] = 0;
    end
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic run(int count, int dly, bit gaps, int seed);
    for (int k = 0; k < count; k++)
      step(gaps ? (k % 3 != 1) : 1'b1, 16'(k * 977 + seed * 131 + 7), dly);
  endtask

  // Scoreboard monitor: samples 3 ns after each rising edge
  initial begin
    forever begin
      bit en_c, rst_c;
      bit chg_c [2], errp_c [2];
      @(posedge clk);
      en_c = in_en; rst_c = rst;
      for (int i = 0; i < 2; i++) begin chg_c[i] = chg[i]; errp_c[i] = errp[i]; end
      #3;
      for (int i = 0; i < 2; i++) begin
        if (rst_c) begin
          exp_v[i] = 0; exp_e[i] = 0;
          cmp("R1 out_valid after reset", i, 16'(ov[i]), 16'd0);
          cmp("R1 cfg_err after reset", i, 16'(oe[i]), 16'd0);
        end else begin
          if (en_c) begin
            if (cnt[i] >= eff[i]) begin
              exp_v[i] = 1;
              exp_d[i] = hist[hist.size() - eff[i]];
            end else exp_v[i] = 0;
          end else if (chg_c[i]) exp_v[i] = 0;
          if (errp_c[i]) exp_e[i] = 1;
          cmp("R6 out_valid", i, 16'(ov[i]), 16'(exp_v[i]));
          if (exp_v[i]) cmp("R2 out_data", i, od[i], exp_d[i]);
          cmp("R9 cfg_err", i, 16'(oe[i]), 16'(exp_e[i]));
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog expired at t=%0t", $time);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    do_reset(4);                 // R1
    run(30, 4, 0, 1);            // R2, R6: continuous stream, delay 4
    run(30, 4, 1, 2);            // R3: enable gaps, delay counted in samples
    run(20, 1, 0, 3);            // R4, R7, R10: delay of one in both modes
    run(40, 12, 1, 4);           // R5: u1 at its maximum depth
    run(24, 5, 0, 5);            // R7: change delay mid-stream
    run(20, 3, 0, 6);
    run(40, 16, 0, 7);           // R5 for u0; R9 clamp and sticky error for u1
    run(30, 20, 1, 8);           // R9: both clamp, error stays set
    run(10, 3, 0, 9);            // R9: sticky even after legal delay
    do_reset(3);                 // R1: reset clears sticky error
    run(12, 3, 0, 10);
    run(20, 0, 0, 11);           // R8: zero acts as one, sets error
    step(1'b0, 16'h0, 2);        // R7: change with enable low
    run(12, 2, 1, 12);
    step(1'b0, 16'h0, 2);
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule